// File: doc/BRIEF.md
# SIMD Divergence Reconvergence Stack

This block keeps the control-flow state of one SIMD warp whose lanes may disagree on the outcome of a conditional branch. It holds a small stack. Each entry records three things: the PC at which its lanes rejoin, the PC they fetch next, and a mask of the lanes that take part. The entry on top always supplies the fetch PC and the active lane mask that the pipeline uses for the next instruction.

A branch strobe brings a per-lane taken vector, the taken target, the fall-through PC and the rejoin PC encoded with the branch. If the active lanes all agree, only the top entry's next PC moves. If they split, three things happen. The top entry is parked at the rejoin PC. An entry for the not-taken lanes is pushed. An entry for the taken lanes is pushed above it, so the taken side runs first. A sequential advance input moves the top entry's next PC in ordinary straight-line flow. When the top entry's next PC reaches its own rejoin PC, the entry is retired one level per cycle. During those cycles a hold output tells the front end to wait. Nested splits stack further entries, and a split that does not fit raises a sticky overflow flag.

Top module: `simd_reconv_stack`

## Requirements
- R1: After reset, fetch_pc equals EXIT_PC, active_mask is all zeros, and both overflow and hold are 0.
- R2: A start pulse loads a single bottom entry with fetch_pc = start_pc, an all-ones mask and rejoin PC EXIT_PC, and it clears overflow. Advancing the bottom entry to EXIT_PC never raises hold. Start takes priority over a branch or advance in the same cycle.
- R3: A branch is uniform when the taken bits of all active lanes are equal. A uniform branch changes fetch_pc to br_target (all active lanes taken) or to br_fallthru (none taken) on the next cycle. active_mask is unchanged. Taken bits of inactive lanes have no effect.
- R4: A divergent branch presents br_target on the cycle after it, with active_mask equal to the taken bits ANDed with the previous mask.
- R5: When the taken entry reaches its rejoin PC and is retired, br_fallthru is presented with the mask of the active lanes that resolved not-taken.
- R6: When the not-taken entry is retired, the entry beneath resumes at the rejoin PC with its original mask.
- R7: An adv_valid pulse with no branch or start sets fetch_pc to adv_pc on the next cycle. The mask is unchanged.
- R8: hold is 1 exactly while the top entry is above the bottom and its next PC equals its rejoin PC. Each cycle with hold high retires one entry. Branch and advance inputs in that cycle are ignored.
- R9: Nested splits sharing one rejoin PC retire in successive hold cycles. Execution then continues on the outer not-taken path.
- R10: A divergent branch when fewer than two entries are free sets overflow and leaves fetch_pc and active_mask unchanged. overflow stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a warp at start_pc |
| start_pc | input | PC_W | First PC of the warp |
| br_valid | input | 1 | Branch resolution strobe |
| br_taken | input | LANES | Per-lane taken outcome |
| br_target | input | PC_W | Taken target PC |
| br_fallthru | input | PC_W | Fall-through PC |
| br_reconv | input | PC_W | Rejoin PC carried by the branch |
| adv_valid | input | 1 | Sequential next-PC update |
| adv_pc | input | PC_W | Next PC for sequential flow |
| fetch_pc | output | PC_W | Next PC of the top entry |
| active_mask | output | LANES | Lane mask of the top entry |
| hold | output | 1 | Top entry is being retired, inputs ignored |
| overflow | output | 1 | Sticky: a split was dropped for lack of room |

## Verification
A corrupted stack entry stays hidden until the entries above it are retired. A wrong not-taken mask or rejoin PC therefore first shows at the ports only after the taken path finishes. This can be several instructions after the branch that wrote it. The sweeps drive each split through to full rejoin, so every pushed field reaches fetch_pc and active_mask within a few cycles of its retirement. A wrong level count shows at once as a missing or extra hold cycle.

// File: rtl/reconv_pkg.sv
// Shared definitions for the divergence reconvergence stack.
// Assumes: one stack operation is applied per clock cycle.
package reconv_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_INIT  = 3'd1,
        OP_SET   = 3'd2,
        OP_SPLIT = 3'd3,
        OP_POP   = 3'd4
    } stack_op_e;
endpackage

// File: rtl/reconv_branch_eval.sv
// Splits a branch outcome into taken and not-taken masks restricted to the
// currently active lanes, and flags whether those lanes disagree.
// Assumes: the lanes that are inactive in cur_mask have taken bits that must be ignored.
module reconv_branch_eval #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] taken,
    output logic [LANES-1:0] tk_mask,
    output logic [LANES-1:0] nt_mask,
    output logic             diverge,
    output logic             any_taken
);
    // Mask outcome by active lanes and classify the branch.
    always_comb begin
        tk_mask   = taken & cur_mask;
        nt_mask   = ~taken & cur_mask;
        any_taken = |tk_mask;
        diverge   = (|tk_mask) && (|nt_mask);
    end
endmodule

// File: rtl/reconv_stack_mem.sv
// Entry storage and level counter for the reconvergence stack.
// Applies the operation chosen by the controller and exposes the top entry.
// Assumes: the controller never requests SPLIT without two free entries
// and never requests POP at the bottom level.
module reconv_stack_mem
    import reconv_pkg::*;
#(
    parameter int          LANES   = 8,
    parameter int          PC_W    = 16,
    parameter int          DEPTH   = 16,
    parameter int          LVL_W   = $clog2(DEPTH + 1),
    parameter logic [PC_W-1:0] EXIT_PC = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_op_e        op,
    input  logic [PC_W-1:0]  init_pc,
    input  logic [PC_W-1:0]  set_pc,
    input  logic [PC_W-1:0]  split_rpc,
    input  logic [PC_W-1:0]  split_nt_pc,
    input  logic [LANES-1:0] split_nt_mask,
    input  logic [PC_W-1:0]  split_tk_pc,
    input  logic [LANES-1:0] split_tk_mask,
    output logic [PC_W-1:0]  top_rpc,
    output logic [PC_W-1:0]  top_npc,
    output logic [LANES-1:0] top_mask,
    output logic [LVL_W-1:0] level
);
    logic [PC_W-1:0]  rpc_q  [DEPTH];
    logic [PC_W-1:0]  npc_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];
    logic [LVL_W-1:0] level_q;
    int               top_i;

    // Index of the entry currently on top.
    always_comb top_i = int'(level_q) - 1;

    // Per-entry write port: init, next-PC rewrite, or one of the two pushes.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rpc_q[g]  <= EXIT_PC;
                npc_q[g]  <= EXIT_PC;
                mask_q[g] <= '0;
            end else if (op == OP_INIT && g == 0) begin
                rpc_q[g]  <= EXIT_PC;
                npc_q[g]  <= init_pc;
                mask_q[g] <= '1;
            end else if (op == OP_SET && g == top_i) begin
                npc_q[g]  <= set_pc;
            end else if (op == OP_SPLIT && g == top_i) begin
                npc_q[g]  <= split_rpc;
            end else if (op == OP_SPLIT && g == int'(level_q)) begin
                rpc_q[g]  <= split_rpc;
                npc_q[g]  <= split_nt_pc;
                mask_q[g] <= split_nt_mask;
            end else if (op == OP_SPLIT && g == int'(level_q) + 1) begin
                rpc_q[g]  <= split_rpc;
                npc_q[g]  <= split_tk_pc;
                mask_q[g] <= split_tk_mask;
            end
        end
    end

    // Track the number of live entries.
    always_ff @(posedge clk) begin
        if (!rst_n)                level_q <= LVL_W'(1);
        else if (op == OP_INIT)    level_q <= LVL_W'(1);
        else if (op == OP_SPLIT)   level_q <= level_q + LVL_W'(2);
        else if (op == OP_POP)     level_q <= level_q - LVL_W'(1);
    end

    // Present the top entry.
    always_comb begin
        top_rpc  = rpc_q[top_i];
        top_npc  = npc_q[top_i];
        top_mask = mask_q[top_i];
        level    = level_q;
    end

    // R10
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= LVL_W'(1)) && (int'(level_q) <= DEPTH));

    // R8
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |=> (level_q == $past(level_q) - LVL_W'(1)));

    // R4
    split_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SPLIT) |=> (level_q == $past(level_q) + LVL_W'(2)));
endmodule

// File: rtl/simd_reconv_stack.sv
// Divergence reconvergence stack for one SIMD warp.
// Chooses one stack operation per cycle (start > retire > branch > advance),
// keeps the sticky overflow flag and exposes the top entry as fetch state.
// Assumes: the front end stalls while hold is high; DEPTH >= 3.
module simd_reconv_stack
    import reconv_pkg::*;
#(
    parameter int          LANES   = 8,
    parameter int          PC_W    = 16,
    parameter int          DEPTH   = 16,
    parameter logic [PC_W-1:0] EXIT_PC = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] active_mask,
    output logic             hold,
    output logic             overflow
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    stack_op_e        op;
    logic [PC_W-1:0]  set_pc;
    logic [PC_W-1:0]  top_rpc, top_npc;
    logic [LANES-1:0] top_mask, tk_mask, nt_mask;
    logic [LVL_W-1:0] level;
    logic             diverge, any_taken, room, ovf_q;

    reconv_branch_eval #(.LANES(LANES)) u_eval (
        .cur_mask (top_mask),
        .taken    (br_taken),
        .tk_mask  (tk_mask),
        .nt_mask  (nt_mask),
        .diverge  (diverge),
        .any_taken(any_taken)
    );

    reconv_stack_mem #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .EXIT_PC(EXIT_PC)
    ) u_mem (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .init_pc      (start_pc),
        .set_pc       (set_pc),
        .split_rpc    (br_reconv),
        .split_nt_pc  (br_fallthru),
        .split_nt_mask(nt_mask),
        .split_tk_pc  (br_target),
        .split_tk_mask(tk_mask),
        .top_rpc      (top_rpc),
        .top_npc      (top_npc),
        .top_mask     (top_mask),
        .level        (level)
    );

    // Retire pending when a non-bottom top entry has reached its rejoin PC.
    always_comb begin
        hold = (top_npc == top_rpc) && (level > LVL_W'(1));
        room = int'(level) <= DEPTH - 2;
    end

    // Pick the single stack operation for this cycle.
    always_comb begin
        op     = OP_NONE;
        set_pc = adv_pc;
        if (start) begin
            op = OP_INIT;
        end else if (hold) begin
            op = OP_POP;
        end else if (br_valid) begin
            if (diverge) begin
                op = room ? OP_SPLIT : OP_NONE;
            end else begin
                op     = OP_SET;
                set_pc = any_taken ? br_target : br_fallthru;
            end
        end else if (adv_valid) begin
            op = OP_SET;
        end
    end

    // Sticky overflow: set by a dropped split, cleared by warp start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ovf_q <= 1'b0;
        else if (start)                                    ovf_q <= 1'b0;
        else if (!hold && br_valid && diverge && !room)    ovf_q <= 1'b1;
    end

    // Drive the fetch-side outputs from the top entry.
    always_comb begin
        fetch_pc    = top_npc;
        active_mask = top_mask;
        overflow    = ovf_q;
    end

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    // R8
    hold_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> (level == $past(level) - LVL_W'(1)));

    // R3
    uniform_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !start && !hold && !diverge) |=> $stable(active_mask));

    // R4
    split_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !start && !hold && diverge && room) |=>
            (active_mask == $past(tk_mask)) && (fetch_pc == $past(br_target)));

    // R10
    dropped_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !start && !hold && diverge && !room) |=>
            ($stable(fetch_pc) && $stable(active_mask) && overflow));
endmodule

// File: tb/simd_reconv_stack_test.sv
`timescale 1ns/1ps
module simd_reconv_stack_test;
    localparam int LN = 4;
    localparam int PW = 12;
    localparam int DP = 5;
    localparam logic [PW-1:0] EXITV = 12'hFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [PW-1:0] start_pc = '0;
    logic          br_valid = 1'b0;
    logic [LN-1:0] br_taken = '0;
    logic [PW-1:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic          adv_valid = 1'b0;
    logic [PW-1:0] adv_pc = '0;
    logic [PW-1:0] fetch_pc;
    logic [LN-1:0] active_mask;
    logic          hold, overflow;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    simd_reconv_stack #(.LANES(LN), .PC_W(PW), .DEPTH(DP), .EXIT_PC(EXITV)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .fetch_pc(fetch_pc), .active_mask(active_mask),
        .hold(hold), .overflow(overflow)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go(input logic [PW-1:0] pc);
        start = 1'b1; start_pc = pc; cyc(); start = 1'b0;
    endtask

    task automatic br(input logic [LN-1:0] t, input logic [PW-1:0] tg,
                      input logic [PW-1:0] ft, input logic [PW-1:0] rc);
        br_valid = 1'b1; br_taken = t; br_target = tg; br_fallthru = ft; br_reconv = rc;
        cyc(); br_valid = 1'b0;
    endtask

    task automatic adv(input logic [PW-1:0] pc);
        adv_valid = 1'b1; adv_pc = pc; cyc(); adv_valid = 1'b0;
    endtask

    // Reach the rejoin PC, expect one hold cycle, then let it retire.
    task automatic rejoin(input logic [PW-1:0] rc, input string tag);
        adv(rc);
        chk({tag, " R8 hold"}, 32'(hold), 32'd1);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        // R1 reset state
        chk("R1 fetch_pc", 32'(fetch_pc), 32'(EXITV));
        chk("R1 mask", 32'(active_mask), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        chk("R1 hold", 32'(hold), 32'd0);
        rst_n = 1'b1;
        cyc();

        // R2 start, bottom never retires at EXIT_PC
        go(12'h100);
        chk("R2 fetch_pc", 32'(fetch_pc), 32'h100);
        chk("R2 mask", 32'(active_mask), 32'hF);
        adv(EXITV);
        chk("R2 bottom hold", 32'(hold), 32'd0);
        chk("R2 bottom pc", 32'(fetch_pc), 32'(EXITV));

        // R7 sequential advance
        go(12'h100);
        adv(12'h104);
        chk("R7 fetch_pc", 32'(fetch_pc), 32'h104);
        chk("R7 mask", 32'(active_mask), 32'hF);

        // R2 start has priority over branch and advance
        br_valid = 1'b1; br_taken = 4'h5; br_target = 12'h222; adv_valid = 1'b1;
        go(12'h0A0);
        br_valid = 1'b0; adv_valid = 1'b0;
        chk("R2 priority pc", 32'(fetch_pc), 32'h0A0);
        chk("R2 priority mask", 32'(active_mask), 32'hF);

        // Sweep all taken patterns from a full warp: R3 R4 R5 R6
        for (int p = 0; p < 16; p++) begin
            logic [LN-1:0] tk, nt;
            tk = LN'(p); nt = ~tk;
            go(12'h100);
            br(tk, 12'h200, 12'h110, 12'h300);
            if (tk == '0) begin
                chk("R3 none-taken pc", 32'(fetch_pc), 32'h110);
                chk("R3 none-taken mask", 32'(active_mask), 32'hF);
            end else if (nt == '0) begin
                chk("R3 all-taken pc", 32'(fetch_pc), 32'h200);
                chk("R3 all-taken mask", 32'(active_mask), 32'hF);
            end else begin
                chk("R4 taken pc", 32'(fetch_pc), 32'h200);
                chk("R4 taken mask", 32'(active_mask), 32'(tk));
                rejoin(12'h300, "taken");
                chk("R5 nt pc", 32'(fetch_pc), 32'h110);
                chk("R5 nt mask", 32'(active_mask), 32'(nt));
                rejoin(12'h300, "nottaken");
                chk("R6 rejoin pc", 32'(fetch_pc), 32'h300);
                chk("R6 rejoin mask", 32'(active_mask), 32'hF);
                chk("R6 no hold", 32'(hold), 32'd0);
            end
        end

        // Nested sweep inside a 0111 taken path; bit 3 is inactive: R3 R4 R5 R6 R9
        for (int q = 0; q < 16; q++) begin
            logic [LN-1:0] itk, int_nt;
            itk = LN'(q) & 4'h7; int_nt = ~LN'(q) & 4'h7;
            go(12'h100);
            br(4'h7, 12'h200, 12'h110, 12'h300);
            br(LN'(q), 12'h400, 12'h410, 12'h500);
            if (itk == '0) begin
                chk("R3 inner none pc", 32'(fetch_pc), 32'h410);
                chk("R3 inner none mask", 32'(active_mask), 32'h7);
            end else if (int_nt == '0) begin
                chk("R3 inner all pc", 32'(fetch_pc), 32'h400);
                chk("R3 inner all mask", 32'(active_mask), 32'h7);
            end else begin
                chk("R4 inner taken mask", 32'(active_mask), 32'(itk));
                rejoin(12'h500, "inner taken");
                chk("R5 inner nt pc", 32'(fetch_pc), 32'h410);
                chk("R5 inner nt mask", 32'(active_mask), 32'(int_nt));
                rejoin(12'h500, "inner nt");
                chk("R6 inner rejoin pc", 32'(fetch_pc), 32'h500);
                chk("R6 inner rejoin mask", 32'(active_mask), 32'h7);
            end
            rejoin(12'h300, "R9 outer taken");
            chk("R9 outer nt pc", 32'(fetch_pc), 32'h110);
            chk("R9 outer nt mask", 32'(active_mask), 32'h8);
        end

        // R9 chained retire with a shared rejoin PC; R8 ignores inputs during hold
        go(12'h100);
        br(4'h7, 12'h200, 12'h110, 12'h300);
        br(4'h1, 12'h400, 12'h410, 12'h300);
        chk("R9 deep mask", 32'(active_mask), 32'h1);
        rejoin(12'h300, "R9 inner tk");
        chk("R9 inner nt mask", 32'(active_mask), 32'h6);
        adv(12'h300);
        chk("R8 hold before chain", 32'(hold), 32'd1);
        adv_valid = 1'b1; adv_pc = 12'h777;
        br_valid = 1'b1; br_taken = 4'h3; br_target = 12'h666;
        cyc();
        adv_valid = 1'b0; br_valid = 1'b0;
        chk("R9 chain hold", 32'(hold), 32'd1);
        cyc();
        chk("R8 ignored pc", 32'(fetch_pc), 32'h110);
        chk("R8 ignored mask", 32'(active_mask), 32'h8);
        chk("R9 chain settled", 32'(hold), 32'd0);

        // R10 overflow at level 5 of 5
        go(12'h100);
        br(4'h7, 12'h200, 12'h110, 12'h300);
        br(4'h3, 12'h400, 12'h410, 12'h500);
        chk("R10 before pc", 32'(fetch_pc), 32'h400);
        br(4'h1, 12'h600, 12'h610, 12'h700);
        chk("R10 flag", 32'(overflow), 32'd1);
        chk("R10 pc kept", 32'(fetch_pc), 32'h400);
        chk("R10 mask kept", 32'(active_mask), 32'h3);
        br(4'h3, 12'h420, 12'h430, 12'h500);
        chk("R10 sticky", 32'(overflow), 32'd1);
        chk("R3 uniform at full", 32'(fetch_pc), 32'h420);
        go(12'h100);
        chk("R10 cleared by start", 32'(overflow), 32'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule